// File: doc/BRIEF.md
# Sequential Shift Unit

This block is the shift function of an ALU. A control sequencer presents an operand, a shift amount and a two-bit function code, and pulses `start` for one cycle. The unit then moves the operand one bit position per clock. When the last step is done it raises `done` for exactly one cycle. The sequencer waits on that pulse and then takes `result`, plus `ovf` for the sign-preserving left shift.

Four kinds of shift are supported: logical left, logical right, arithmetic left and arithmetic right. The arithmetic left shift keeps the sign bit in place and moves only the bits below it. Any shift amount is accepted. Amounts of `WIDTH` or more are clamped to `WIDTH` steps, which gives the saturated result for each kind.

The sequencing is a three-state machine:
- IDLE waits for `start`. If the clamped amount is zero it goes to FINISH; otherwise it goes to SHIFT.
- SHIFT performs one step per cycle. It goes to FINISH once the remaining step count reaches one.
- FINISH drives `done` and always returns to IDLE.

Top module: `shift_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted start, `result` is 0, `done` is 0 and `ovf` is 0.
- R2: Function code 2'b00 is a logical left shift. Each step drops bit WIDTH-1 and brings a 0 into bit 0.
- R3: Function code 2'b01 is a logical right shift. Each step drops bit 0 and brings a 0 into bit WIDTH-1.
- R4: Function code 2'b10 is an arithmetic left shift. Bit WIDTH-1 never changes. Each step drops bit WIDTH-2 and brings a 0 into bit 0.
- R5: Function code 2'b11 is an arithmetic right shift. Bit WIDTH-1 never changes. Each step drops bit 0 and brings a copy of the sign into bit WIDTH-2.
- R6: `done` is high for exactly one cycle, min(count, WIDTH)+1 cycles after the clock edge that accepts `start`. With a count of 0, `done` follows on the next cycle and `result` equals the operand.
- R7: A count of WIDTH or more gives all zeros for both logical shifts. It gives the sign over zeros for the arithmetic left shift and all copies of the sign for the arithmetic right shift.
- R8: `ovf` is 1 after an arithmetic left shift in which any bit leaving position WIDTH-2 differed from the sign bit. It is cleared when a start is accepted and stays 0 for the other three functions.
- R9: `start` is accepted only in IDLE. A start seen from the accepting edge up to and including the `done` cycle has no effect on `result` or on timing.
- R10: After `done`, `result` and `ovf` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a shift |
| fn | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASL, 11 ASR |
| operand | input | WIDTH | Value to be shifted |
| count | input | CNT_W | Shift amount, as an immediate |
| result | output | WIDTH | Shifted value |
| done | output | 1 | One-cycle completion feedback |
| ovf | output | 1 | Sign lost during arithmetic left shift |

## Verification
The bench drives directed scenarios for each shift kind and compares the results with a bit-by-bit model.

**Zero count.** A design that entered SHIFT anyway would be one cycle late and might shift once.

**Counts of exactly WIDTH, above WIDTH, and the maximum field value.** A design without clamping would either take up to 31 cycles or wrap its step counter.

**Arithmetic left with a 1 in bit WIDTH-2.** A design that treated ASL as a logical shift would lose the sign and never flag `ovf`. A design that did not clear `ovf` on start would carry a stale flag into a later operation.

**Start pulse during SHIFT.** A design that reloaded on that pulse would return the poked operand and report the wrong latency.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        FN_LSL = 2'b00,
        FN_LSR = 2'b01,
        FN_ASL = 2'b10,
        FN_ASR = 2'b11
    } shift_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SHIFT  = 2'b01,
        ST_FINISH = 2'b10
    } seq_state_e;

endpackage

// File: rtl/shift_step.sv
module shift_step
    import shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] din,
    input  shift_fn_e        fn,
    output logic [WIDTH-1:0] dout,
    output logic             sign_lost
);

    // One position of movement; the sign lane is untouched for arithmetic kinds.
    always_comb begin
        sign_lost = 1'b0;
        unique case (fn)
            FN_LSL: dout = {din[WIDTH-2:0], 1'b0};
            FN_LSR: dout = {1'b0, din[WIDTH-1:1]};
            FN_ASL: begin
                dout      = {din[WIDTH-1], din[WIDTH-3:0], 1'b0};
                sign_lost = din[WIDTH-2] ^ din[WIDTH-1];
            end
            FN_ASR: dout = {din[WIDTH-1], din[WIDTH-1:1]};
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import shift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             step,
    output logic             done,
    output seq_state_e       state_o
);

    localparam int REM_W = $clog2(WIDTH + 1);

    seq_state_e       state_q, state_d;
    logic [REM_W-1:0] rem_q, rem_d, clamped;

    // Amounts beyond the operand width saturate to WIDTH steps.
    always_comb begin
        if (32'(cnt) >= WIDTH) clamped = REM_W'(WIDTH);
        else                   clamped = REM_W'(cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        load    = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    rem_d   = clamped;
                    state_d = (clamped == '0) ? ST_FINISH : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                step  = 1'b1;
                rem_d = rem_q - 1'b1;
                if (rem_q == REM_W'(1)) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/shift_dpath.sv
module shift_dpath
    import shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  shift_fn_e        fn_in,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] data_o,
    output logic             ovf_o,
    output shift_fn_e        fn_o
);

    logic [WIDTH-1:0] data_q, stepped;
    logic             ovf_q, lost;
    shift_fn_e        fn_q;

    shift_step #(.WIDTH(WIDTH)) u_step (
        .din       (data_q),
        .fn        (fn_q),
        .dout      (stepped),
        .sign_lost (lost)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ovf_q  <= 1'b0;
            fn_q   <= FN_LSL;
        end else if (load) begin
            data_q <= opnd;
            ovf_q  <= 1'b0;
            fn_q   <= fn_in;
        end else if (step) begin
            data_q <= stepped;
            if (lost) ovf_q <= 1'b1;
        end
    end

    assign data_o = data_q;
    assign ovf_o  = ovf_q;
    assign fn_o   = fn_q;

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       fn,
    input  logic [WIDTH-1:0] operand,
    input  logic [CNT_W-1:0] count,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             ovf
);

    logic       load, step;
    seq_state_e seq_state;
    shift_fn_e  active_fn;

    shift_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cnt     (count),
        .load    (load),
        .step    (step),
        .done    (done),
        .state_o (seq_state)
    );

    shift_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .fn_in  (shift_fn_e'(fn)),
        .opnd   (operand),
        .data_o (result),
        .ovf_o  (ovf),
        .fn_o   (active_fn)
    );

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
    import shift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             ovf,
    input logic [WIDTH-1:0] result,
    input seq_state_e       state,
    input shift_fn_e        active_fn
);

    // R6: completion feedback lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the flag can only stand after a sign-preserving left shift
    a_r8_ovf_asl_only: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (active_fn == FN_ASL));

    // R10: idle without a request leaves the result alone
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(result));

    // R4 and R5: arithmetic steps keep the top bit
    a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && active_fn[1]) |=> (result[WIDTH-1] == $past(result[WIDTH-1])));

    // R9: a busy sequence never falls back to idle mid-shift
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> (state != ST_IDLE));

endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .ovf       (ovf),
    .result    (result),
    .state     (seq_state),
    .active_fn (active_fn)
);

// File: tb/shift_unit_test.sv
`timescale 1ns/1ps
module shift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  fn = 2'b00;
    logic [15:0] operand = '0;
    logic [4:0]  count = '0;
    logic [15:0] result;
    logic        done;
    logic        ovf;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shift_unit #(.WIDTH(16), .CNT_W(5)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fn      (fn),
        .operand (operand),
        .count   (count),
        .result  (result),
        .done    (done),
        .ovf     (ovf)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bit-by-bit model of the four shift kinds; returns {ovf, result}.
    function automatic logic [16:0] model(input logic [15:0] op, input logic [1:0] f, input int c);
        logic [15:0] d = op;
        logic        o = 1'b0;
        int          n = (c > 16) ? 16 : c;
        for (int i = 0; i < n; i++) begin
            case (f)
                2'b00: d = d << 1;
                2'b01: d = d >> 1;
                2'b10: begin
                    if (d[14] != d[15]) o = 1'b1;
                    d = {d[15], d[13:0], 1'b0};
                end
                default: d = 16'($signed(d) >>> 1);
            endcase
        end
        return {o, d};
    endfunction

    task automatic do_op(input logic [15:0] op, input logic [1:0] f, input int c,
                         input logic [15:0] er, input logic eo, input string tag, input bit poke);
        int lat = 0;
        int explat = ((c > 16) ? 16 : c) + 1;
        @(negedge clk);
        operand = op; fn = f; count = 5'(c); start = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            start = poke && (lat == 1);
            if (poke) operand = ~op;
        end while (!done && lat < 200);
        start = 1'b0;
        check(lat == explat, {tag, " R6 latency"}, lat, explat);
        check(result == er, {tag, " result"}, result, er);
        check(ovf == eo, {tag, " R8 ovf"}, ovf, eo);
        @(negedge clk);
        check(!done, {tag, " R6 single pulse"}, done, 0);
        @(negedge clk);
        check(result == er, {tag, " R10 hold"}, result, er);
        check(ovf == eo, {tag, " R10 ovf hold"}, ovf, eo);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(result == 16'h0, "R1 result", result, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(ovf == 1'b0, "R1 ovf", ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(result == 16'h0 && !done && !ovf, "R1 after release", {result, done, ovf}, 0);
    endtask

    task automatic t_directed();
        do_op(16'h00F1, 2'b00, 4,  16'h0F10, 1'b0, "R2 lsl", 1'b0);
        do_op(16'h8421, 2'b01, 5,  16'h0421, 1'b0, "R3 lsr", 1'b0);
        do_op(16'hC001, 2'b10, 1,  16'h8002, 1'b0, "R4 asl keep", 1'b0);
        do_op(16'h4000, 2'b10, 1,  16'h0000, 1'b1, "R4 asl lose", 1'b0);
        do_op(16'h8000, 2'b11, 3,  16'hF000, 1'b0, "R5 asr", 1'b0);
        do_op(16'h1234, 2'b10, 0,  16'h1234, 1'b0, "R6 zero count", 1'b0);
        do_op(16'h4000, 2'b00, 1,  16'h8000, 1'b0, "R8 lsl no ovf", 1'b0);
    endtask

    task automatic t_saturate();
        do_op(16'hFFFF, 2'b00, 16, 16'h0000, 1'b0, "R7 lsl 16", 1'b0);
        do_op(16'hFFFF, 2'b01, 20, 16'h0000, 1'b0, "R7 lsr 20", 1'b0);
        do_op(16'h9234, 2'b10, 31, 16'h8000, 1'b1, "R7 asl 31", 1'b0);
        do_op(16'h9234, 2'b11, 16, 16'hFFFF, 1'b0, "R7 asr 16", 1'b0);
        do_op(16'h7234, 2'b11, 20, 16'h0000, 1'b0, "R7 asr pos", 1'b0);
    endtask

    task automatic t_busy_start();
        do_op(16'h0F0F, 2'b00, 3, 16'h7878, 1'b0, "R9 poke lsl", 1'b1);
        do_op(16'hA5A5, 2'b11, 6, 16'hFE96, 1'b0, "R9 poke asr", 1'b1);
    endtask

    task automatic t_sweep();
        logic [15:0] pats [4] = '{16'h8001, 16'h3C5A, 16'hB7E1, 16'h0100};
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 4; f++) begin
                for (int c = 0; c < 19; c += 3) begin
                    logic [16:0] e = model(pats[p], 2'(f), c);
                    do_op(pats[p], 2'(f), c, e[15:0], e[16], "R2-R5 sweep", 1'b0);
                end
            end
        end
    endtask

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_directed();
        t_saturate();
        t_busy_start();
        t_sweep();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule